// File: doc/BRIEF.md
# Dual Tick-Aligned Interval Pulse Generator

This block sits beside a precision time counter and turns its nominal tick stream into two independent periodic pulse trains. Each generator holds a programmed period in nanoseconds. It subtracts the tick period from a running countdown on every tick strobe. When the remaining time drops below one tick, it starts a pulse and reloads itself, with no software help. The programmed value is the wanted interval minus one tick period. For example, a 100 µs interval on a 10 ns tick is programmed as 99990, and one pulse per second is programmed as 999999990.

Each pulse lasts one output-clock period, which is the prescaler value counted in ticks. Every pulse start also sets a sticky per-generator event flag that can drive an interrupt. The flag stays set until software writes a 1 to its clear bit. The first generator normally carries the one-pulse-per-second signal used to discipline system time.

Top module: `tick_pulse_pair`

## Requirements
- R1: While reset is active and after it is released, every pulse output and every event flag is 0.
- R2: With the enable high, after a restart with period P and tick period T (in ns), generator g starts its pulse on tick number floor(P/T)+1. The pulse output is high in the clock cycle after that tick.
- R3: Once a generator has fired, it reloads P and fires again every floor(P/T)+1 ticks without further writes.
- R4: A pulse stays high for exactly S ticks, where S is the prescaler input. A prescaler of 0 behaves as 1.
- R5: Clock cycles without a tick strobe change neither the countdown nor the pulse output. Intervals and widths are counted in ticks, not in clock cycles.
- R6: When the enable is low, all pulse outputs are low from the next cycle and each countdown is reloaded from its period. After the enable rises again, the first pulse comes floor(P/T)+1 ticks later.
- R7: A write strobe on bit g of the period-write input loads the write data as generator g's new period and restarts its countdown. The write takes precedence over a tick in the same cycle, and the next pulse arrives floor(Pnew/T)+1 ticks after the write.
- R8: Event flag bit g goes high in the same cycle as pulse g rises. It stays high until bit g of the clear input is 1 in a cycle. If a set and a clear happen in the same cycle, the set wins.
- R9: The two generators count independently, each with its own period and its own pulse and flag bit (bit 0 and bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Tick strobe from the time counter, one cycle per tick |
| tick_ns_i | input | TICK_W | Nominal tick period in ns |
| prsc_i | input | PRSC_W | Prescaler: pulse width in ticks |
| en_i | input | 1 | Global enable for both generators |
| per_wr_i | input | N_GEN | Period-write strobe, one bit per generator |
| per_wdata_i | input | PER_W | Period value for a write, in ns |
| flag_clr_i | input | N_GEN | Write-1-to-clear for the event flags |
| pulse_o | output | N_GEN | Periodic pulse outputs |
| flag_o | output | N_GEN | Sticky event flags |

## Verification
The bench builds the block with two generators, a 32-bit period, an 8-bit tick period and an 8-bit prescaler. These widths allow tick periods from 5 ns to 10 ns, including ones that do not divide the programmed period, so the floor-plus-one rule is tested with and without remainder. The 100 µs setting on a 10 ns tick, a 10000-tick interval, fits inside the run. The one-second setting does not fit, because it needs 10^8 ticks. Sparse ticks, one every three clock cycles, show that intervals and widths follow ticks rather than cycles. A zero prescaler, an enable drop in the middle of a pulse and a period rewrite while counting exercise the edge cases.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
  localparam int unsigned TPP_N_GEN  = 2;
  localparam int unsigned TPP_PER_W  = 32;
  localparam int unsigned TPP_TICK_W = 8;
  localparam int unsigned TPP_PRSC_W = 16;
endpackage

// File: rtl/tpp_interval_cnt.sv
module tpp_interval_cnt #(
  parameter int unsigned PER_W  = 32,
  parameter int unsigned TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [TICK_W-1:0] tick_ns_i,
  input  logic              wr_i,
  input  logic [PER_W-1:0]  wdata_i,
  output logic              fire_o
);
  localparam int unsigned PAD_W = PER_W - TICK_W;

  logic [PER_W-1:0] per_q, per_d;
  logic [PER_W-1:0] rem_q, rem_d;
  logic [PER_W-1:0] step;
  logic             rem_ld;

  assign step = {{PAD_W{1'b0}}, tick_ns_i};

  // next state: a write wins, then the disable reload, then a tick
  always_comb begin
    per_d  = per_q;
    rem_d  = rem_q;
    fire_o = 1'b0;
    if (wr_i) begin
      per_d = wdata_i;
      rem_d = wdata_i;
    end else if (!en_i) begin
      rem_d = per_q;
    end else if (tick_i) begin
      if (rem_q < step) begin
        fire_o = 1'b1;
        rem_d  = per_q;
      end else begin
        rem_d  = rem_q - step;
      end
    end
  end

  assign rem_ld = wr_i | ~en_i | tick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      rem_q <= '0;
    end else begin
      if (wr_i)   per_q <= per_d;
      if (rem_ld) rem_q <= rem_d;
    end
  end
endmodule

// File: rtl/tpp_pulse_width.sv
module tpp_pulse_width #(
  parameter int unsigned PRSC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              fire_i,
  input  logic [PRSC_W-1:0] width_i,
  output logic              pulse_o
);
  logic [PRSC_W-1:0] left_q, left_d;
  logic              left_ld;

  always_comb begin
    left_d = left_q;
    if (!en_i)
      left_d = '0;
    else if (fire_i)
      left_d = width_i;
    else if (tick_i && (left_q != '0))
      left_d = left_q - 1'b1;
  end

  assign left_ld = ~en_i | fire_i | tick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      left_q <= '0;
    else if (left_ld)
      left_q <= left_d;
  end

  assign pulse_o = (left_q != '0);
endmodule

// File: rtl/tpp_event_flag.sv
module tpp_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_d;

  // a set arriving with a clear keeps the flag high
  always_comb flag_d = set_i | (flag_o & ~clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_o <= 1'b0;
    else if (set_i | clr_i)
      flag_o <= flag_d;
  end
endmodule

// File: rtl/tick_pulse_pair.sv
module tick_pulse_pair
  import tpp_pkg::*;
#(
  parameter int unsigned N_GEN  = TPP_N_GEN,
  parameter int unsigned PER_W  = TPP_PER_W,
  parameter int unsigned TICK_W = TPP_TICK_W,
  parameter int unsigned PRSC_W = TPP_PRSC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [TICK_W-1:0] tick_ns_i,
  input  logic [PRSC_W-1:0] prsc_i,
  input  logic              en_i,
  input  logic [N_GEN-1:0]  per_wr_i,
  input  logic [PER_W-1:0]  per_wdata_i,
  input  logic [N_GEN-1:0]  flag_clr_i,
  output logic [N_GEN-1:0]  pulse_o,
  output logic [N_GEN-1:0]  flag_o
);
  localparam logic [PRSC_W-1:0] ONE_TICK = PRSC_W'(1);

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [PRSC_W-1:0] width_eff;
  logic [N_GEN-1:0]  fire;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe_q <= 2'b00;
    else
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign width_eff = (prsc_i == '0) ? ONE_TICK : prsc_i;

  for (genvar g = 0; g < N_GEN; g++) begin : g_gen
    tpp_interval_cnt #(.PER_W(PER_W), .TICK_W(TICK_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .en_i      (en_i),
      .tick_i    (tick_i),
      .tick_ns_i (tick_ns_i),
      .wr_i      (per_wr_i[g]),
      .wdata_i   (per_wdata_i),
      .fire_o    (fire[g])
    );

    tpp_pulse_width #(.PRSC_W(PRSC_W)) u_width (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .en_i    (en_i),
      .tick_i  (tick_i),
      .fire_i  (fire[g]),
      .width_i (width_eff),
      .pulse_o (pulse_o[g])
    );

    tpp_event_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .set_i  (fire[g]),
      .clr_i  (flag_clr_i[g]),
      .flag_o (flag_o[g])
    );
  end
endmodule

// File: rtl/tpp_checker.sv
module tpp_checker #(
  parameter int unsigned N_GEN = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             en_i,
  input logic [N_GEN-1:0] flag_clr_i,
  input logic [N_GEN-1:0] pulse_o,
  input logic [N_GEN-1:0] flag_o
);
  for (genvar g = 0; g < N_GEN; g++) begin : g_chk
    AST_OFF_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !pulse_o[g]); // R6
    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_o[g]) |-> $past(tick_i && en_i)); // R2
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !tick_i) |=> $stable(pulse_o[g])); // R5
    AST_FLAG_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_o[g]) |-> flag_o[g]); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[g] && !flag_clr_i[g]) |=> flag_o[g]); // R8
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i[g] && !tick_i) |=> !flag_o[g]); // R8
  end
endmodule

bind tick_pulse_pair tpp_checker #(.N_GEN(N_GEN)) u_tpp_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .en_i       (en_i),
  .flag_clr_i (flag_clr_i),
  .pulse_o    (pulse_o),
  .flag_o     (flag_o)
);

// File: tb/tick_pulse_pair_tb.sv
module tick_pulse_pair_tb;
  localparam int unsigned N_GEN  = 2;
  localparam int unsigned PER_W  = 32;
  localparam int unsigned TICK_W = 8;
  localparam int unsigned PRSC_W = 8;
  localparam int unsigned NVEC   = 5;

  // tick_ns, prescaler, period gen0, period gen1
  localparam int unsigned VEC [NVEC][4] = '{
    '{10, 2, 40, 95},
    '{10, 1, 45, 10},
    '{7,  2, 69, 20},
    '{5,  0, 5,  14},
    '{10, 4, 45, 99990}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              tick_i;
  logic [TICK_W-1:0] tick_ns_i;
  logic [PRSC_W-1:0] prsc_i;
  logic              en_i;
  logic [N_GEN-1:0]  per_wr_i;
  logic [PER_W-1:0]  per_wdata_i;
  logic [N_GEN-1:0]  flag_clr_i;
  logic [N_GEN-1:0]  pulse_o;
  logic [N_GEN-1:0]  flag_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  tick_pulse_pair #(.N_GEN(N_GEN), .PER_W(PER_W), .TICK_W(TICK_W), .PRSC_W(PRSC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .tick_ns_i(tick_ns_i), .prsc_i(prsc_i),
    .en_i(en_i), .per_wr_i(per_wr_i), .per_wdata_i(per_wdata_i), .flag_clr_i(flag_clr_i),
    .pulse_o(pulse_o), .flag_o(flag_o)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_per(input int g, input int unsigned val);
    per_wr_i    = '0;
    per_wr_i[g] = 1'b1;
    per_wdata_i = val;
    @(negedge clk);
    per_wr_i    = '0;
  endtask

  task automatic run_vec(input int unsigned tk, input int unsigned pr,
                         input int unsigned p0, input int unsigned p1);
    int unsigned exp_int[2];
    int unsigned exp_w;
    int unsigned first[2];
    int unsigned second[2];
    int unsigned width[2];
    bit          prev[2];
    int unsigned limit;
    en_i = 1'b0; tick_i = 1'b0; tick_ns_i = TICK_W'(tk); prsc_i = PRSC_W'(pr);
    write_per(0, p0);
    write_per(1, p1);
    exp_int[0] = p0 / tk + 1;
    exp_int[1] = p1 / tk + 1;
    exp_w = (pr == 0) ? 1 : pr;
    limit = 2 * ((exp_int[0] > exp_int[1]) ? exp_int[0] : exp_int[1]) + exp_w + 4;
    for (int g = 0; g < 2; g++) begin
      first[g] = 0; second[g] = 0; width[g] = 0; prev[g] = 1'b0;
    end
    en_i = 1'b1; tick_i = 1'b1;
    for (int unsigned c = 1; c <= limit; c++) begin
      @(negedge clk);
      for (int g = 0; g < 2; g++) begin
        if (pulse_o[g] && !prev[g]) begin
          if (first[g] == 0) first[g] = c;
          else if (second[g] == 0) second[g] = c;
        end
        if (pulse_o[g] && first[g] != 0 && second[g] == 0) width[g]++;
        prev[g] = pulse_o[g];
      end
    end
    chk("R2", "gen0 first pulse tick", first[0], exp_int[0]);
    chk("R9", "gen1 first pulse tick", first[1], exp_int[1]);
    chk("R3", "gen0 rearm spacing", second[0] - first[0], exp_int[0]);
    chk("R3", "gen1 rearm spacing", second[1] - first[1], exp_int[1]);
    chk("R4", "gen0 width", width[0], exp_w);
    chk("R4", "gen1 width", width[1], exp_w);
    en_i = 1'b0; tick_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int c;
    int ts;
    int hi;
    int rise_ts;
    bit tick_prev;
    rst_n = 1'b0; tick_i = 1'b0; tick_ns_i = '0; prsc_i = '0; en_i = 1'b0;
    per_wr_i = '0; per_wdata_i = '0; flag_clr_i = '0;
    repeat (3) @(negedge clk);
    chk("R1", "pulse in reset", pulse_o, 0);
    chk("R1", "flag in reset", flag_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "pulse after reset", pulse_o, 0);
    chk("R1", "flag after reset", flag_o, 0);

    // vector table
    for (int v = 0; v < NVEC; v++)
      run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

    // R8: flags held with no ticks, then cleared per bit
    repeat (3) @(negedge clk);
    chk("R8", "flags held", flag_o, 3);
    flag_clr_i = 2'b01;
    @(negedge clk);
    flag_clr_i = 2'b00;
    chk("R8", "clear bit 0 only", flag_o, 2);

    // R6: enable drop during a pulse
    tick_ns_i = 8'd10; prsc_i = 8'd2;
    write_per(0, 40);
    write_per(1, 95);
    en_i = 1'b1; tick_i = 1'b1;
    c = 0;
    while (!pulse_o[0] && c < 50) begin @(negedge clk); c++; end
    chk("R2", "first rise before drop", c, 5);
    en_i = 1'b0;
    @(negedge clk);
    chk("R6", "pulse low after disable", pulse_o[0], 0);
    @(negedge clk);
    en_i = 1'b1;
    c = 0;
    while (!pulse_o[0] && c < 50) begin @(negedge clk); c++; end
    chk("R6", "restart from full period", c, 5);

    // R7: rewrite period while counting, tick present on write cycle
    repeat (3) @(negedge clk);
    chk("R7", "pulse low before write", pulse_o[0], 0);
    per_wr_i = 2'b01; per_wdata_i = 20;
    @(negedge clk);
    per_wr_i = 2'b00;
    c = 0;
    while (!pulse_o[0] && c < 50) begin @(negedge clk); c++; end
    chk("R7", "ticks to pulse after write", c, 3);

    // R5: sparse ticks, one every three cycles
    en_i = 1'b0; tick_i = 1'b0;
    write_per(0, 30);
    en_i = 1'b1; tick_i = 1'b1; tick_prev = 1'b1;
    ts = 0; hi = 0; rise_ts = -1;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (tick_prev) ts++;
      if (pulse_o[0] && rise_ts < 0) rise_ts = ts;
      if (pulse_o[0] && rise_ts >= 0 && ts <= rise_ts + 2) hi++;
      tick_i = (k % 3 == 0);
      tick_prev = tick_i;
    end
    chk("R5", "rise counted in ticks", rise_ts, 4);
    chk("R5", "width in cycles for 2 sparse ticks", hi, 6);

    en_i = 1'b0; tick_i = 1'b0;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule